// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a memory-mapped interval timer. A prescaler divides the peripheral clock by 8, 32 or 128, or passes it through undivided. Each resulting tick advances an up-counter while the channel's run input is high. The run input is that channel's bit in a shared start register, which lives outside this block. When a tick arrives while the count equals the compare register, the counter returns to zero instead of advancing. On that same cycle the block sets two sticky status flags: a match flag and an overflow flag. Depending on a two-bit steering field, the match can also raise a level interrupt or emit a one-cycle DMA request strobe.

Software reaches three word-wide registers over a simple word-addressed bus: a control/status word, the count and the compare value. A write to the count does not take effect at once. It passes through a synchroniser that waits for a fixed number of prescaled ticks, so reads return the old, still-running count until the new value lands. A pending bit in the status word shows that a count write is still in flight.

The synchroniser is a three-state machine. SYNC_IDLE means no write is pending. SYNC_WAIT counts the first ticks after a write. SYNC_LOAD waits for the final tick, on which the stored value is loaded. These are its transitions:

- IDLE→WAIT on a count write.
- WAIT→WAIT on a further count write, which restarts the wait with the new value.
- WAIT→LOAD on a tick once the wait counter is exhausted.
- LOAD→IDLE on a tick, which also performs the load.
- LOAD→WAIT on a count write.

Top module: `mtc_channel`

## Requirements
- R1: After reset the control/status word reads 0, the count reads 0, the compare value reads 0xFFFFFFFF, and both irq_o and dma_req_o are low.
- R2: The word offsets are fixed. Offset 0 is control/status, offset 1 is the count, offset 2 is the compare value, and offset 3 reads 0 and ignores writes. The control/status fields are:
  - bit 15: match flag
  - bit 14: overflow flag
  - bit 13: count-write pending (read-only)
  - bit 8: match-mode select (stored and read back; no effect on counting)
  - bit 7: interrupt enable
  - bits 5:4: request steering
  - bits 2:0: clock select
  - all other bits read 0.
- R3: Clock select 4 gives one tick per 8 clocks, 5 one per 32, 6 one per 128, and 7 one per clock. Codes 0 to 3 give no ticks. The prescaler restarts from zero whenever run_en is low, so the first tick after run rises comes on the 8th, 32nd, 128th or 1st clock.
- R4: While run_en is low the count holds its value.
- R5: A tick while the count equals the compare value reloads the count with 0, so one match period lasts compare + 1 ticks.
- R6: The match sets the match flag and the overflow flag on the same cycle. Both stay set until software clears them.
- R7: A control/status write clears a flag whose written bit is 0 and leaves it unchanged where the written bit is 1. A match in the same cycle wins over the clear.
- R8: A count write becomes visible on the 4th tick after the write. Until then reads return the old count, which keeps counting. The pending bit reads 1 from the cycle after the write until that load. A further count write while one is pending restarts the wait with the new value.
- R9: irq_o is high exactly while the match flag is set, the interrupt enable is 1 and the steering field is 10.
- R10: With steering 01, each match drives dma_req_o high for one clock, in the cycle after the match. With any other steering no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | This channel's bit of the shared start register |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Level interrupt request |
| dma_req_o | output | 1 | One-cycle DMA request strobe |

## Verification
Different internal faults show up at the ports on different timescales:

- A synchroniser stuck in the wrong state appears on the next status read as a wrong pending bit. A mis-counted wait shows as the count jumping to its written value one tick early or late.
- A wrong divider or a prescaler that is not cleared shows as an off-by-some count after a fixed run burst with run_en then frozen.
- A bad wrap or flag path is seen at the very next match: the count fails to return to 0, a flag stays low, irq_o misbehaves, or the DMA strobe count comes out wrong.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    localparam int DATA_W = 32;

    localparam logic [1:0] OFF_CTRL = 2'd0;
    localparam logic [1:0] OFF_CNT  = 2'd1;
    localparam logic [1:0] OFF_CMP  = 2'd2;

    localparam int BIT_MFLAG = 15;
    localparam int BIT_OFLAG = 14;
    localparam int BIT_PEND  = 13;
    localparam int BIT_MODE  = 8;
    localparam int BIT_IE    = 7;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'b00,
        ROUTE_DMA  = 2'b01,
        ROUTE_IRQ  = 2'b10,
        ROUTE_RSVD = 2'b11
    } route_e;

    typedef enum logic [1:0] {
        SYNC_IDLE,
        SYNC_WAIT,
        SYNC_LOAD
    } sync_state_e;
endpackage

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
    parameter int MAX_DIV_LOG2 = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] cks,
    output logic       tick
);
    localparam int PRE_W = MAX_DIV_LOG2;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        unique case (cks[1:0])
            2'd0:    mask = PRE_W'(7);
            2'd1:    mask = PRE_W'(31);
            2'd2:    mask = PRE_W'(127);
            default: mask = '0;
        endcase
    end

    assign tick = run && cks[2] && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre_q <= '0;
        else if (run) pre_q <= pre_q + 1'b1;
        else          pre_q <= '0;
    end

    // R3: no tick is possible while the channel is stopped
    assert_no_tick_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));
endmodule

// File: rtl/mtc_wrsync.sv
module mtc_wrsync
    import mtc_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SYNC_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             tick,
    output logic             pending,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam int RW = (SYNC_TICKS > 2) ? $clog2(SYNC_TICKS - 1) : 1;
    localparam logic [RW-1:0] REM_INIT = RW'(SYNC_TICKS - 2);

    sync_state_e state_q, state_d;
    logic [RW-1:0]    rem_q;
    logic [CNT_W-1:0] val_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_IDLE: if (wr_req) state_d = SYNC_WAIT;
            SYNC_WAIT: begin
                if (wr_req)                        state_d = SYNC_WAIT;
                else if (tick && rem_q == '0)      state_d = SYNC_LOAD;
            end
            SYNC_LOAD: begin
                if (wr_req)    state_d = SYNC_WAIT;
                else if (tick) state_d = SYNC_IDLE;
            end
            default: state_d = SYNC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYNC_IDLE;
            rem_q   <= '0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_req) begin
                rem_q <= REM_INIT;
                val_q <= wr_val;
            end else if (state_q == SYNC_WAIT && tick && rem_q != '0) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    always_comb begin
        pending  = (state_q != SYNC_IDLE);
        load     = (state_q == SYNC_LOAD) && tick && !wr_req;
        load_val = val_q;
    end

    assert_wr_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> pending);
    assert_load_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !pending);
endmodule

// File: rtl/mtc_channel.sv
module mtc_channel
    import mtc_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int SYNC_TICKS   = 4,
    parameter int MAX_DIV_LOG2 = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              dma_req_o
);
    logic [CNT_W-1:0] count_q, cmp_q, load_val;
    logic             mflag_q, oflag_q, mode_q, ie_q, dma_q;
    route_e           route_q;
    logic [2:0]       cks_q;
    logic             tick, pending, load, match_hit;
    logic             ctrl_wr, cnt_wr, cmp_wr;

    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
    assign cnt_wr  = bus_sel && bus_wr && (bus_addr == OFF_CNT);
    assign cmp_wr  = bus_sel && bus_wr && (bus_addr == OFF_CMP);

    mtc_prescaler #(.MAX_DIV_LOG2(MAX_DIV_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_en), .cks(cks_q), .tick(tick)
    );

    mtc_wrsync #(.CNT_W(CNT_W), .SYNC_TICKS(SYNC_TICKS)) u_sync (
        .clk(clk), .rst_n(rst_n), .wr_req(cnt_wr),
        .wr_val(bus_wdata[CNT_W-1:0]), .tick(tick),
        .pending(pending), .load(load), .load_val(load_val)
    );

    assign match_hit = tick && !load && (count_q == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            cmp_q   <= '1;
            mflag_q <= 1'b0;
            oflag_q <= 1'b0;
            mode_q  <= 1'b0;
            ie_q    <= 1'b0;
            route_q <= ROUTE_NONE;
            cks_q   <= 3'd0;
            dma_q   <= 1'b0;
        end else begin
            if (load)           count_q <= load_val;
            else if (match_hit) count_q <= '0;
            else if (tick)      count_q <= count_q + 1'b1;

            if (cmp_wr) cmp_q <= bus_wdata[CNT_W-1:0];

            mflag_q <= match_hit || (mflag_q && !(ctrl_wr && !bus_wdata[BIT_MFLAG]));
            oflag_q <= match_hit || (oflag_q && !(ctrl_wr && !bus_wdata[BIT_OFLAG]));
            if (ctrl_wr) begin
                mode_q  <= bus_wdata[BIT_MODE];
                ie_q    <= bus_wdata[BIT_IE];
                route_q <= route_e'(bus_wdata[5:4]);
                cks_q   <= bus_wdata[2:0];
            end
            dma_q <= match_hit && (route_q == ROUTE_DMA);
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[BIT_MFLAG] = mflag_q;
                bus_rdata[BIT_OFLAG] = oflag_q;
                bus_rdata[BIT_PEND]  = pending;
                bus_rdata[BIT_MODE]  = mode_q;
                bus_rdata[BIT_IE]    = ie_q;
                bus_rdata[5:4]       = route_q;
                bus_rdata[2:0]       = cks_q;
            end
            OFF_CNT: bus_rdata = DATA_W'(count_q);
            OFF_CMP: bus_rdata = DATA_W'(cmp_q);
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o     = mflag_q && ie_q && (route_q == ROUTE_IRQ);
    assign dma_req_o = dma_q;

    assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(count_q));
    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> (count_q == '0));
    assert_both_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> (mflag_q && oflag_q));
    assert_w1_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[BIT_MFLAG] && mflag_q) |=> mflag_q);
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(match_hit) && ie_q && route_q == ROUTE_IRQ) |-> irq_o);
    assert_dma_after_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> $past(match_hit));
endmodule

// File: tb/sim_mtc_channel.sv
module sim_mtc_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, dma_req_o;

    int n_tests = 0;
    int n_fail = 0;
    int dma_cnt = 0;
    bit mon_req = 1'b0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mtc_channel u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    // scoreboard monitor: pops expected read data and compares
    always @(negedge clk) begin
        if (dma_req_o) dma_cnt++;
        if (mon_req && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=0x%08h expected=0x%08h", t, bus_rdata, e);
            end
            mon_req = 1'b0;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        mon_req = 1'b1;
        @(negedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic chk(input logic act, input logic e, input string t);
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", t, act, e);
        end
    endtask

    task automatic chk_int(input int act, input int e, input string t);
        n_tests++;
        if (act != e) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, e);
        end
    endtask

    task automatic run_cycles(input int k);
        @(posedge clk); #1;
        run_en = 1'b1;
        repeat (k) @(posedge clk);
        #1 run_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 32'h0, "R1 ctrl reset");
        rd(2'd1, 32'h0, "R1 count reset");
        rd(2'd2, 32'hFFFF_FFFF, "R1 compare reset");
        chk(irq_o, 1'b0, "R1 irq reset");
        chk(dma_req_o, 1'b0, "R1 dma reset");

        // R2 layout, R5 wrap, R6 flags, R9 irq
        wr(2'd2, 32'd9);
        wr(2'd0, 32'h0000_01A7);
        rd(2'd0, 32'h0000_01A7, "R2 ctrl fields with mode bit");
        run_cycles(7);
        rd(2'd1, 32'd7, "R4 count frozen after 7 ticks");
        chk(irq_o, 1'b0, "R9 irq low before match");
        run_cycles(3);
        rd(2'd1, 32'd0, "R5 wrap to zero after compare+1 ticks");
        rd(2'd0, 32'h0000_C1A7, "R6 both flags set");
        chk(irq_o, 1'b1, "R9 irq on match");

        // R7 flag clearing
        wr(2'd0, 32'h0000_C1A7);
        rd(2'd0, 32'h0000_C1A7, "R7 write ones keeps flags");
        wr(2'd0, 32'h0000_41A7);
        rd(2'd0, 32'h0000_41A7, "R7 write zero clears match flag");
        chk(irq_o, 1'b0, "R9 irq drops with flag");
        wr(2'd0, 32'h0000_01A7);
        rd(2'd0, 32'h0000_01A7, "R7 overflow flag cleared");

        // R3 clock select
        wr(2'd0, 32'h0000_00A4);
        run_cycles(24);
        rd(2'd1, 32'd3, "R3 divide by 8");
        wr(2'd0, 32'h0000_00A5);
        run_cycles(64);
        rd(2'd1, 32'd5, "R3 divide by 32");
        wr(2'd0, 32'h0000_00A6);
        run_cycles(128);
        rd(2'd1, 32'd6, "R3 divide by 128");
        wr(2'd0, 32'h0000_00A0);
        run_cycles(50);
        rd(2'd1, 32'd6, "R3 code 0 gives no ticks");

        // R8 count write synchroniser
        wr(2'd0, 32'h0000_0007);
        wr(2'd1, 32'd100);
        rd(2'd0, 32'h0000_2007, "R8 pending bit set");
        rd(2'd1, 32'd6, "R8 old count visible");
        run_cycles(3);
        rd(2'd1, 32'd9, "R8 old count still running after 3 ticks");
        rd(2'd0, 32'h0000_2007, "R8 still pending");
        run_cycles(1);
        rd(2'd1, 32'd100, "R8 value loaded on 4th tick");
        rd(2'd0, 32'h0000_0007, "R8 pending cleared");

        // R10 DMA strobe
        wr(2'd2, 32'd200);
        wr(2'd0, 32'h0000_0017);
        dma_cnt = 0;
        run_cycles(101);
        repeat (3) @(posedge clk);
        #1;
        chk_int(dma_cnt, 1, "R10 one dma strobe per match");
        chk(irq_o, 1'b0, "R9 no irq with dma steering");
        rd(2'd0, 32'h0000_C017, "R6 flags with dma steering");
        rd(2'd1, 32'd0, "R5 wrap from loaded value");
        wr(2'd0, 32'h0000_0007);
        rd(2'd0, 32'h0000_0007, "R7 clear both flags");
        run_cycles(201);
        repeat (3) @(posedge clk);
        #1;
        chk_int(dma_cnt, 1, "R10 no strobe with steering none");
        rd(2'd0, 32'h0000_C007, "R6 match with steering none");
        chk(irq_o, 1'b0, "R9 no irq with steering none");

        // R9 enable gating
        wr(2'd0, 32'h0000_C027);
        #1 chk(irq_o, 1'b0, "R9 irq steering but enable off");
        wr(2'd0, 32'h0000_C0A7);
        #1 chk(irq_o, 1'b1, "R9 irq enabled on pending flag");

        // R2 unused offset
        wr(2'd3, 32'h1234_5678);
        rd(2'd3, 32'h0, "R2 offset 3 reads zero");
        rd(2'd2, 32'd200, "R2 offset 3 write ignored");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule